// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block holds the interrupt state of a general-purpose peripheral interface chip. Seven interrupt sources each own one flag bit. Neighbouring blocks raise a flag with a one-cycle set pulse: the timers, the shift register and the port control-line detectors. A flag is cleared in one of three ways: a clear strobe from a neighbour, a write of ones to the flag register, or a read of the shift-register data address, which clears the shift-register flag. A separate seven-bit enable register selects which flags may reach the single active-high interrupt request line.

Software reaches both registers through an 8-bit port. A write to the enable register uses data bit 7 as an action selector: 1 means set the enables marked with a 1, and 0 means clear them. A read of the flag register returns a computed summary in bit 7, which is 1 when any flag is both pending and enabled. A read of the enable register always returns 1 in bit 7. The request line is registered, so it follows the flag and enable state one clock later.

Top module: `irq_flag_ctrl`

## Requirements
- R1: `irq_o` is a register: after each rising edge it is 1 exactly when, just before that edge, at least one flag bit and its enable bit were both 1.
- R2: A write to `EN_ADDR` (default 14) with data bit 7 = 1 sets every enable bit whose data bit in 6..0 is 1 and leaves the other enable bits unchanged.
- R3: A write to `EN_ADDR` with data bit 7 = 0 clears every enable bit whose data bit in 6..0 is 1 and leaves the other enable bits unchanged.
- R4: While `bus_addr` equals `EN_ADDR`, `rd_data` is {1, enables[6:0]}.
- R5: While `bus_addr` equals `FLAG_ADDR` (default 13), `rd_data` bits 6..0 are the flags, and bit 7 is 1 exactly when some flag and its enable are both 1 in the current state.
- R6: A write to `FLAG_ADDR` clears each flag whose data bit in 6..0 is 1. Flags written with 0 are unchanged, and data bit 7 has no effect.
- R7: A 1 on `src_set[i]` sets flag i at the next edge. Flag positions: shift register = bit 2, timer 2 = bit 5, timer 1 = bit 6. Bits 0, 1, 3 and 4 serve port control-line sources.
- R8: A 1 on `src_clr[i]` clears flag i at the next edge.
- R9: A cycle with `bus_rd` = 1 and `bus_addr` = `SRDAT_ADDR` (default 10) clears flag bit 2 only.
- R10: When a set and any clear reach the same flag in one cycle, the flag ends set.
- R11: While `rst_n` is 0 at a rising edge, all flags and enables become 0 and `irq_o` becomes 0.
- R12: At any address other than `FLAG_ADDR` and `EN_ADDR`, `rd_data` is 0 and a write changes neither flags nor enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| src_set | input | 7 | Per-source set pulses |
| src_clr | input | 7 | Per-source clear strobes from neighbouring blocks |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_rd | input | 1 | Read strobe, used for clear-on-read of the shift-register flag |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request, active high, registered |

## Verification
The bench uses the default of seven sources and a 4-bit address. At this size every 8-bit enable write value, every 7-bit flag clear mask and every set pattern against a spread of clear strobes can be applied one by one. Each is followed by a read-back through the port and a check of the request line one cycle later. A long pseudo-random run then mixes set pulses, clear strobes, clear-on-read and writes to foreign addresses, so that set-versus-clear collisions and the summary bit occur in many combinations.

// File: rtl/irq_pkg.sv
// Package: shared constants and types of the interrupt flag/enable controller.
// Assumes a single clock domain and one summary bit above the source bits.
package irq_pkg;
    localparam int NSRC_DEF   = 7;   // number of interrupt sources
    localparam int BIT_SR     = 2;   // shift-register source position
    localparam int BIT_TMR2   = 5;   // timer 2 source position
    localparam int BIT_TMR1   = 6;   // timer 1 source position
    localparam int ADDR_W_DEF = 4;

    // Action requested on the enable register by a write.
    typedef enum logic [1:0] {
        EN_HOLD  = 2'd0,
        EN_SET   = 2'd1,
        EN_CLEAR = 2'd2
    } en_op_e;
endpackage

// File: rtl/irq_flag_bank.sv
// Flag bank: one flag bit per source.
// Set pulses win over every clear source in the same cycle.
// Assumes clear inputs are already merged by the caller.
module irq_flag_bank #(
    parameter int NSRC = irq_pkg::NSRC_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] flag_o
);
    logic [NSRC-1:0] flag_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        // Purpose: hold one flag, set beats clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[i] <= 1'b0;
            else if (set_i[i])
                flag_q[i] <= 1'b1;
            else if (clr_i[i])
                flag_q[i] <= 1'b0;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/irq_enable_reg.sv
// Enable register: set or clear selected enable bits by the requested action.
// Assumes the caller decodes the action from the write data's top bit.
module irq_enable_reg #(
    parameter int NSRC = irq_pkg::NSRC_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  irq_pkg::en_op_e op_i,
    input  logic [NSRC-1:0] mask_i,
    output logic [NSRC-1:0] en_o
);
    import irq_pkg::*;

    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] en_d;

    // Purpose: next enable value for the requested action.
    always_comb begin
        case (op_i)
            EN_SET:   en_d = en_q | mask_i;
            EN_CLEAR: en_d = en_q & ~mask_i;
            default:  en_d = en_q;
        endcase
    end

    // Purpose: store the enables.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else
            en_q <= en_d;
    end

    assign en_o = en_q;
endmodule

// File: rtl/irq_request_out.sv
// Request stage: registers whether any flag is both pending and enabled.
// Assumes flags and enables are register outputs of the same clock.
module irq_request_out #(
    parameter int NSRC = irq_pkg::NSRC_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] flag_i,
    input  logic [NSRC-1:0] en_i,
    output logic            irq_o
);
    logic irq_q;

    // Purpose: register the enabled-pending reduction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |(flag_i & en_i);
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/irq_read_mux.sv
// Read mux: presents flag register (with summary bit) or enable register
// (top bit forced to one); other addresses read zero.
// Assumes one-hot or zero hit inputs.
module irq_read_mux #(
    parameter int NSRC = irq_pkg::NSRC_DEF,
    localparam int DW  = NSRC + 1
) (
    input  logic            hit_flag_i,
    input  logic            hit_en_i,
    input  logic [NSRC-1:0] flag_i,
    input  logic [NSRC-1:0] en_i,
    output logic [DW-1:0]   rd_data_o
);
    logic pending;

    // Purpose: summary of enabled pending flags, independent of the request stage.
    always_comb pending = (flag_i & en_i) != '0;

    // Purpose: select the read word.
    always_comb begin
        if (hit_flag_i)
            rd_data_o = {pending, flag_i};
        else if (hit_en_i)
            rd_data_o = {1'b1, en_i};
        else
            rd_data_o = '0;
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
// Top: interrupt flag and enable controller.
// Decodes the register port, merges clear sources and drives the request line.
// Assumes the address is stable while bus_wr or bus_rd is high.
module irq_flag_ctrl #(
    parameter int NSRC        = irq_pkg::NSRC_DEF,
    parameter int ADDR_W      = irq_pkg::ADDR_W_DEF,
    parameter int FLAG_ADDR   = 13,
    parameter int EN_ADDR     = 14,
    parameter int SRDAT_ADDR  = 10,
    parameter int SR_BIT      = irq_pkg::BIT_SR,
    localparam int DW         = NSRC + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_set,
    input  logic [NSRC-1:0]   src_clr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     rd_data,
    output logic              irq_o
);
    import irq_pkg::*;

    logic            hit_flag, hit_en, hit_srdat;
    logic [NSRC-1:0] wr_clr_mask, rd_clr_mask, clr_all;
    logic [NSRC-1:0] flag_q, en_q;
    en_op_e          en_op;

    // Purpose: address decode.
    always_comb begin
        hit_flag  = bus_addr == ADDR_W'(FLAG_ADDR);
        hit_en    = bus_addr == ADDR_W'(EN_ADDR);
        hit_srdat = bus_addr == ADDR_W'(SRDAT_ADDR);
    end

    // Purpose: merge every clear source of the flags.
    always_comb begin
        wr_clr_mask = (bus_wr && hit_flag) ? bus_wdata[NSRC-1:0] : '0;
        rd_clr_mask = '0;
        if (bus_rd && hit_srdat)
            rd_clr_mask[SR_BIT] = 1'b1;
        clr_all = wr_clr_mask | rd_clr_mask | src_clr;
    end

    // Purpose: decode the enable-write action from the top data bit.
    always_comb begin
        if (!(bus_wr && hit_en))
            en_op = EN_HOLD;
        else if (bus_wdata[DW-1])
            en_op = EN_SET;
        else
            en_op = EN_CLEAR;
    end

    irq_flag_bank #(.NSRC(NSRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(src_set), .clr_i(clr_all), .flag_o(flag_q)
    );

    irq_enable_reg #(.NSRC(NSRC)) u_en (
        .clk(clk), .rst_n(rst_n), .op_i(en_op), .mask_i(bus_wdata[NSRC-1:0]), .en_o(en_q)
    );

    irq_request_out #(.NSRC(NSRC)) u_req (
        .clk(clk), .rst_n(rst_n), .flag_i(flag_q), .en_i(en_q), .irq_o(irq_o)
    );

    irq_read_mux #(.NSRC(NSRC)) u_rmux (
        .hit_flag_i(hit_flag), .hit_en_i(hit_en), .flag_i(flag_q), .en_i(en_q),
        .rd_data_o(rd_data)
    );
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
// Checker: temporal properties of the interrupt flag/enable controller.
// Assumes it is bound to irq_flag_ctrl and sees its internal registers.
module irq_flag_ctrl_chk #(
    parameter int NSRC      = 7,
    parameter int ADDR_W    = 4,
    parameter int FLAG_ADDR = 13,
    parameter int EN_ADDR   = 14,
    localparam int DW       = NSRC + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   src_set,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     rd_data,
    input logic              irq_o,
    input logic [NSRC-1:0]   flag_q,
    input logic [NSRC-1:0]   en_q
);
    // R1: request line follows the enabled-pending state one clock later.
    a_r1_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past((flag_q & en_q) != '0));

    // R2: set-action write turns the selected enables on.
    a_r2_en_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(EN_ADDR) && bus_wdata[DW-1])
        |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

    // R3: clear-action write turns the selected enables off.
    a_r3_en_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(EN_ADDR) && !bus_wdata[DW-1])
        |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == '0));

    // R4: enable read always shows its top bit as one.
    a_r4_en_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(EN_ADDR)) |-> rd_data[DW-1]);

    // R6 with R10: a clear write removes flags that had no set pulse.
    a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(FLAG_ADDR))
        |=> ((flag_q & $past(bus_wdata[NSRC-1:0] & ~src_set)) == '0));

    // R10: a set pulse always leaves its flag set.
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set != '0) |=> ((flag_q & $past(src_set)) == $past(src_set)));

    // R11: first cycle out of reset starts from a clear state.
    a_r11_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flag_q == '0 && en_q == '0 && !irq_o));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(
    .NSRC(NSRC), .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .EN_ADDR(EN_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .rd_data(rd_data), .irq_o(irq_o),
    .flag_q(flag_q), .en_q(en_q)
);

// File: tb/irq_flag_ctrl_tb.sv
// Bench: sweeps enable writes, flag clears, set/clear collisions and a
// pseudo-random mix, against an arithmetic model of the registers.
module irq_flag_ctrl_tb;
    localparam int  CLK_PERIOD = 10;
    localparam int  NSRC = 7;
    localparam int  DW   = NSRC + 1;
    localparam int  AW   = 4;
    localparam logic [AW-1:0] A_FLAG = 4'd13;
    localparam logic [AW-1:0] A_EN   = 4'd14;
    localparam logic [AW-1:0] A_SRD  = 4'd10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_set = '0;
    logic [NSRC-1:0] src_clr = '0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [DW-1:0]   bus_wdata = '0;
    logic [DW-1:0]   rd_data;
    logic            irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // model state
    logic [NSRC-1:0] m_flag = '0;
    logic [NSRC-1:0] m_en   = '0;
    logic            m_irq  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_flag_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
        if (a == A_FLAG) return {((m_flag & m_en) != '0), m_flag};
        if (a == A_EN)   return {1'b1, m_en};
        return '0;
    endfunction

    function automatic string read_tag(input logic [AW-1:0] a);
        if (a == A_FLAG) return "R5";
        if (a == A_EN)   return "R4";
        return "R12";
    endfunction

    // One bus cycle: drive at the falling edge, check outputs, update model at the rising edge.
    task automatic step(input logic [NSRC-1:0] s, input logic [NSRC-1:0] c,
                        input logic [AW-1:0] a, input logic w, input logic r,
                        input logic [DW-1:0] d);
        logic [NSRC-1:0] clr;
        @(negedge clk);
        src_set = s; src_clr = c; bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
        #1;
        chk(read_tag(a), rd_data, model_read(a));
        chk("R1", {7'd0, irq_o}, {7'd0, m_irq});
        @(posedge clk);
        m_irq = (m_flag & m_en) != '0;
        clr = c;
        if (w && a == A_FLAG) clr = clr | d[NSRC-1:0];    // R6
        if (r && a == A_SRD)  clr[2] = 1'b1;             // R9
        m_flag = s | (m_flag & ~clr);                    // R7 R8 R10
        if (w && a == A_EN)
            m_en = d[DW-1] ? (m_en | d[NSRC-1:0])        // R2
                           : (m_en & ~d[NSRC-1:0]);      // R3
    endtask

    task automatic idle(input logic [AW-1:0] a);
        step('0, '0, a, 1'b0, 1'b0, '0);
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        // R11: reset state, even with stimulus applied during reset
        src_set = '1; bus_addr = A_EN; bus_wr = 1'b1; bus_wdata = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        src_set = '0; bus_wr = 1'b0;
        bus_addr = A_FLAG; #1 chk("R11", rd_data, 8'h00);
        bus_addr = A_EN;   #1 chk("R11", rd_data, 8'h80);
        chk("R11", {7'd0, irq_o}, 8'h00);
        rst_n = 1'b1;

        // R2 R3 R4: every enable write value, each read back
        for (int v = 0; v < 256; v++) begin
            step('0, '0, A_EN, 1'b1, 1'b0, DW'(v));
            idle(A_EN);
        end

        // R6: every clear mask against a full set of flags, bit 7 of data toggled
        step('0, '0, A_EN, 1'b1, 1'b0, 8'hFF);
        for (int m = 0; m < 256; m++) begin
            step('1, '0, A_FLAG, 1'b0, 1'b0, '0);
            step('0, '0, A_FLAG, 1'b1, 1'b0, DW'(m));
            idle(A_FLAG);
            idle(A_FLAG);
        end

        // R7 R8 R10: each set pattern against several clear strobes
        for (int s = 0; s < 128; s++) begin
            for (int k = 0; k < 4; k++) begin
                logic [NSRC-1:0] c;
                c = (k == 0) ? 7'h7F : (k == 1) ? NSRC'(s) : (k == 2) ? ~NSRC'(s) : 7'h00;
                step(NSRC'(s), c, A_FLAG, 1'b0, 1'b0, '0);
                idle(A_FLAG);
            end
        end

        // R9: clear-on-read hits only the shift-register flag; R10 on bit 2
        step('1, '0, A_SRD, 1'b0, 1'b1, '0);
        idle(A_FLAG);
        step(7'h04, '0, A_SRD, 1'b0, 1'b1, '0);
        idle(A_FLAG);
        step('0, '0, A_FLAG, 1'b0, 1'b0, '0);

        // R12: foreign addresses ignore writes
        for (int a = 0; a < 16; a++) begin
            if (AW'(a) != A_FLAG && AW'(a) != A_EN) begin
                step('0, '0, AW'(a), 1'b1, 1'b0, (a[0] ? 8'hFF : 8'h7F));
                idle(A_EN);
                idle(A_FLAG);
            end
        end

        // R1 R5 R10: pseudo-random mix
        lfsr = 16'hACE1;
        for (int i = 0; i < 6000; i++) begin
            logic [AW-1:0] a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[1:0])
                2'd0: a = A_FLAG;
                2'd1: a = A_EN;
                2'd2: a = A_SRD;
                default: a = AW'(lfsr[5:2]);
            endcase
            step(lfsr[8:2] & lfsr[15:9], lfsr[14:8] & lfsr[6:0] & {7{lfsr[3]}},
                 a, lfsr[11], lfsr[12], lfsr[15:8]);
        end
        idle(A_FLAG);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule